// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one 16-bit channel that sits beside a free-running 16-bit up-counter. It can work as a compare register or as a capture register, and one mode bit picks which. In compare mode the stored value is checked against the counter value on every clock. On a match, the block raises a one-cycle interrupt pulse. In capture mode the block copies the counter value into the register when a chosen edge appears on one of two external pins. The same interrupt pulse signals each capture.

The two pins are treated differently. Each pin has its own 2-bit edge code. Pin B captures directly on the edge or edges its code names. Pin A captures on the edge opposite to the one its code names, and it never captures when its code selects both edges. Both pins go through a two-flop synchronizer before edge detection, which sets a fixed capture latency. Software can load the register through a write port.

Top module: `tcc_channel`

## Requirements
- R1: `mode_capture` = 0 selects compare behaviour and `mode_capture` = 1 selects capture behaviour. In capture mode, equality of `count` and `reg_val` raises no interrupt.
- R2: In compare mode, `irq` is high for the cycle that follows each clock edge at which `count` equals `reg_val`, and is low otherwise. With a stored value of 0000h, this happens when the counter wraps from FFFFh to 0000h.
- R3: `src_b` = 0 makes pin A the capture source and `src_b` = 1 makes pin B the source. Edges on the pin that is not selected have no effect.
- R4: Pin A with code 00 captures on a rising edge, with code 01 on a falling edge, and with code 11 never.
- R5: Pin B with code 00 captures on a falling edge, with code 01 on a rising edge, and with code 11 on either edge.
- R6: Edge code 10 on either pin gives no capture and no interrupt.
- R7: A pin change that is set up before clock edge 1 causes the capture at clock edge 3. The value latched is `count` as sampled at edge 3, and `irq` is high in the cycle after that edge.
- R8: A capture loads `count` into `reg_val` and gives exactly one `irq` pulse for each pin edge.
- R9: A write with `wr_en` = 1 loads `wr_data` at the next clock. When a capture happens at the same edge, the capture value is stored instead.
- R10: During reset `reg_val` is 0000h and `irq` is 0.
- R11: In compare mode, pin edges change neither `reg_val` nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| count | input | 16 | Counter value |
| mode_capture | input | 1 | 0 = compare, 1 = capture |
| src_b | input | 1 | Capture source: 0 = pin A, 1 = pin B |
| edge_a | input | 2 | Edge code for pin A |
| edge_b | input | 2 | Edge code for pin B |
| pin_a | input | 1 | External pin A, asynchronous |
| pin_b | input | 1 | External pin B, asynchronous |
| reg_val | output | 16 | Current register value |
| irq | output | 1 | Match or capture interrupt pulse |

## Verification
A software write and a pin capture can land on the same clock edge, because both load the one register. The bench toggles pin B and holds the write strobe so that it is sampled at the third edge after the toggle, which is the edge where the synchronized capture fires. It then requires that the register holds the counter value rather than the written data and that the interrupt pulse is present. The next plain write must load normally again.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
    localparam int unsigned TCC_WIDTH   = 16;
    localparam int unsigned TCC_SYNC_FF = 2;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BAD  = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_code_e;
endpackage

// File: rtl/tcc_pin_sync.sv
module tcc_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int unsigned LAST = STAGES;

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [LAST:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[LAST-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise = chain_q[LAST-1] & ~chain_q[LAST];
    assign fall = ~chain_q[LAST-1] & chain_q[LAST];
endmodule

// File: rtl/tcc_edge_map.sv
module tcc_edge_map
    import tcc_pkg::*;
#(
    parameter bit OPPOSITE = 1'b0
) (
    input  logic [1:0] code,
    input  logic       rise,
    input  logic       fall,
    output logic       fire
);
    edge_code_e sel;
    assign sel = edge_code_e'(code);

    generate
        if (OPPOSITE) begin : g_opposite
            // capture on the edge opposite to the valid one; both-edges gives none
            always_comb begin
                unique case (sel)
                    EDGE_FALL: fire = rise;
                    EDGE_RISE: fire = fall;
                    default:   fire = 1'b0;
                endcase
            end
        end else begin : g_direct
            always_comb begin
                unique case (sel)
                    EDGE_FALL: fire = fall;
                    EDGE_RISE: fire = rise;
                    EDGE_BOTH: fire = rise | fall;
                    default:   fire = 1'b0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int unsigned WIDTH   = TCC_WIDTH,
    parameter int unsigned SYNC_FF = TCC_SYNC_FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] count,
    input  logic             mode_capture,
    input  logic             src_b,
    input  logic [1:0]       edge_a,
    input  logic [1:0]       edge_b,
    input  logic             pin_a,
    input  logic             pin_b,
    output logic [WIDTH-1:0] reg_val,
    output logic             irq
);
    typedef struct packed {
        logic [WIDTH-1:0] val;
        logic             irq;
    } chan_t;

    chan_t ch_d, ch_q;
    logic  rise_a, fall_a, rise_b, fall_b;
    logic  fire_a, fire_b, cap_fire, match;

    tcc_pin_sync #(.STAGES(SYNC_FF)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .pin(pin_a), .rise(rise_a), .fall(fall_a)
    );
    tcc_pin_sync #(.STAGES(SYNC_FF)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .pin(pin_b), .rise(rise_b), .fall(fall_b)
    );

    tcc_edge_map #(.OPPOSITE(1'b1)) u_map_a (
        .code(edge_a), .rise(rise_a), .fall(fall_a), .fire(fire_a)
    );
    tcc_edge_map #(.OPPOSITE(1'b0)) u_map_b (
        .code(edge_b), .rise(rise_b), .fall(fall_b), .fire(fire_b)
    );

    assign cap_fire = mode_capture & (src_b ? fire_b : fire_a);
    assign match    = (ch_q.val == count);

    always_comb begin
        ch_d = ch_q;
        if (cap_fire)   ch_d.val = count;
        else if (wr_en) ch_d.val = wr_data;
        ch_d.irq = mode_capture ? cap_fire : match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign reg_val = ch_q.val;
    assign irq     = ch_q.irq;
endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic [WIDTH-1:0] count,
    input logic             mode_capture,
    input logic             src_b,
    input logic [1:0]       edge_a,
    input logic [1:0]       edge_b,
    input logic             cap_fire,
    input logic [WIDTH-1:0] reg_val,
    input logic             irq
);
    assert_compare_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_capture && count == reg_val) |=> irq);

    assert_no_spurious_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_capture ? cap_fire : (count == reg_val)) |=> !irq);

    assert_capture_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (irq && reg_val == $past(count)));

    assert_write_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cap_fire) |=> (reg_val == $past(wr_data)));

    assert_prohibited_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_b && edge_a == 2'b10) |-> !cap_fire);

    assert_prohibited_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_b && edge_b == 2'b10) |-> !cap_fire);

    assert_compare_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_capture && !wr_en) |=> $stable(reg_val));
endmodule

bind tcc_channel tcc_channel_chk #(.WIDTH(WIDTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .count(count),
    .mode_capture(mode_capture), .src_b(src_b), .edge_a(edge_a), .edge_b(edge_b),
    .cap_fire(cap_fire), .reg_val(reg_val), .irq(irq)
);

// File: tb/tcc_channel_tb.sv
`timescale 1ns/1ps
module tcc_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] count;
    logic        mode_capture;
    logic        src_b;
    logic [1:0]  edge_a, edge_b;
    logic        pin_a, pin_b;
    logic [15:0] reg_val;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tcc_channel dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .count(count),
        .mode_capture(mode_capture), .src_b(src_b), .edge_a(edge_a), .edge_b(edge_b),
        .pin_a(pin_a), .pin_b(pin_b), .reg_val(reg_val), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic nedge();
        @(negedge clk);
    endtask

    function automatic bit exp_fire(input bit src, input bit [1:0] code, input bit rising);
        if (!src) begin
            case (code)
                2'b00:   return rising;
                2'b01:   return !rising;
                default: return 1'b0;
            endcase
        end else begin
            case (code)
                2'b00:   return !rising;
                2'b01:   return rising;
                2'b11:   return 1'b1;
                default: return 1'b0;
            endcase
        end
    endfunction

    task automatic do_write(input logic [15:0] v);
        wr_en = 1'b1; wr_data = v;
        nedge();
        wr_en = 1'b0;
    endtask

    task automatic settle_pin(input bit which, input bit lvl);
        if (which) pin_b = lvl; else pin_a = lvl;
        repeat (4) nedge();
    endtask

    // toggles one pin and watches five cycles; returns pulse count and first pulse cycle
    task automatic toggle_watch(input bit which, output int pulses, output int first);
        pulses = 0; first = -1;
        if (which) pin_b = ~pin_b; else pin_a = ~pin_a;
        for (int k = 1; k <= 5; k++) begin
            nedge();
            if (irq) begin
                pulses++;
                if (first < 0) first = k;
            end
        end
    endtask

    initial begin
        #1_500_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int pulses, first;
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; count = 16'h0100;
        mode_capture = 1'b1; src_b = 1'b0; edge_a = 2'b10; edge_b = 2'b10;
        pin_a = 1'b0; pin_b = 1'b0;
        repeat (3) nedge();
        check(reg_val == 16'h0000, "R10 reset value", reg_val, 0);
        check(irq == 1'b0, "R10 reset irq", irq, 0);
        rst_n = 1'b1;
        nedge();

        // capture sweep: source x code x edge direction (R4 R5 R6 R7 R8)
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 4; c++) begin
                for (int d = 0; d < 2; d++) begin
                    bit rising, f;
                    logic [15:0] cv;
                    rising = (d == 0);
                    src_b = s[0];
                    edge_a = 2'b10; edge_b = 2'b10;
                    settle_pin(s[0], !rising);
                    if (s == 0) edge_a = c[1:0]; else edge_b = c[1:0];
                    do_write(16'hDEAD);
                    cv = 16'h1000 + 16'(s * 16 + c * 2 + d);
                    count = cv;
                    f = exp_fire(s[0], c[1:0], rising);
                    toggle_watch(s[0], pulses, first);
                    check(reg_val == (f ? cv : 16'hDEAD),
                          s ? "R5 pin B capture value" : "R4 pin A capture value",
                          reg_val, f ? cv : 16'hDEAD);
                    check(pulses == (f ? 1 : 0),
                          c == 2 ? "R6 prohibited code pulses" : "R8 capture pulse count",
                          pulses, f ? 1 : 0);
                    if (f) check(first == 3, "R7 capture latency", first, 3);
                end
            end
        end

        // unselected pin ignored (R3)
        mode_capture = 1'b1; src_b = 1'b0; edge_a = 2'b00; edge_b = 2'b11;
        settle_pin(1'b0, 1'b0); settle_pin(1'b1, 1'b0);
        do_write(16'h2468); count = 16'h3000;
        toggle_watch(1'b1, pulses, first);
        check(pulses == 0 && reg_val == 16'h2468, "R3 pin B ignored when A selected", reg_val, 16'h2468);
        src_b = 1'b1; edge_a = 2'b00; edge_b = 2'b11;
        toggle_watch(1'b0, pulses, first);
        check(pulses == 0 && reg_val == 16'h2468, "R3 pin A ignored when B selected", reg_val, 16'h2468);

        // capture mode: equality gives no irq (R1)
        edge_a = 2'b10; edge_b = 2'b10;
        do_write(16'h0777); count = 16'h0777;
        pulses = 0;
        for (int k = 0; k < 3; k++) begin nedge(); if (irq) pulses++; end
        check(pulses == 0, "R1 no compare irq in capture mode", pulses, 0);

        // compare mode ignores pins (R11)
        mode_capture = 1'b0; count = 16'h0001;
        do_write(16'h5555);
        edge_a = 2'b00; edge_b = 2'b11; src_b = 1'b1;
        toggle_watch(1'b1, pulses, first);
        check(pulses == 0 && reg_val == 16'h5555, "R11 pin B in compare mode", reg_val, 16'h5555);
        src_b = 1'b0;
        toggle_watch(1'b0, pulses, first);
        check(pulses == 0 && reg_val == 16'h5555, "R11 pin A in compare mode", reg_val, 16'h5555);

        // write loads at next clock (R9)
        do_write(16'h1357);
        check(reg_val == 16'h1357, "R9 write load", reg_val, 16'h1357);

        // write and capture at same edge: capture wins (R9)
        mode_capture = 1'b1; src_b = 1'b1; edge_b = 2'b10;
        settle_pin(1'b1, 1'b0);
        edge_b = 2'b01; count = 16'h4242;
        pin_b = 1'b1;
        nedge(); nedge();
        wr_en = 1'b1; wr_data = 16'hBEEF;
        nedge();
        wr_en = 1'b0;
        check(reg_val == 16'h4242, "R9 capture beats write", reg_val, 16'h4242);
        check(irq == 1'b1, "R9 capture irq on collision", irq, 1);
        do_write(16'hBEEF);
        check(reg_val == 16'hBEEF, "R9 write after collision", reg_val, 16'hBEEF);

        // compare full sweep with stored 0000h, wrap FFFFh->0000h last (R2)
        mode_capture = 1'b0; count = 16'h0001;
        do_write(16'h0000);
        for (int i = 1; i <= 65536; i++) begin
            logic [15:0] cv;
            cv = 16'(i);
            count = cv;
            nedge();
            check(irq == (cv == 16'h0000), "R2 compare sweep at zero", irq, cv == 16'h0000);
        end

        // compare windows around other values (R2)
        foreach (wr_data[b]) begin end
        for (int v = 0; v < 3; v++) begin
            logic [15:0] rv;
            rv = (v == 0) ? 16'hFFFF : (v == 1) ? 16'h8000 : 16'h00FF;
            count = rv + 16'd100;
            do_write(rv);
            for (int o = -4; o <= 4; o++) begin
                logic [15:0] cv;
                cv = rv + 16'(o);
                count = cv;
                nedge();
                check(irq == (o == 0), "R2 compare window", irq, o == 0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule